// File: doc/BRIEF.md
# Jump and Link Next-PC Unit

This block chooses the next program counter for a single-cycle 32-bit processor and steers the register write-back for the jump-and-link case. It looks at the opcode and function fields of the current instruction word and recognises three control transfers: the absolute jump, the absolute jump that saves a return address, and the jump through a register. From these, and from a branch decision made elsewhere, it produces a 2-bit source code and the matching next-PC value. The four choices are sequential (PC+4), branch target, register target and absolute jump target.

The absolute target is made from the top four bits of PC+4, followed by the 26-bit index field of the instruction, followed by two zero bits. For the saving jump, the block replaces the destination register number with the constant 31, because the instruction does not carry that number. It also replaces the write data with PC+4 and forces the register write on. For the plain jump and the register jump, it forces the register write off. For any other instruction, the destination number, the write data and the write enable pass through unchanged from the surrounding datapath.

The selection acts like a four-state choice made again in every cycle. The four states are SEQ (code 00), BRANCH (code 01), REGJMP (code 10) and ABSJMP (code 11). The moves between them follow from decoding alone: a decoded jump moves to ABSJMP or REGJMP, a taken branch moves to BRANCH, and everything else falls back to SEQ.

Top module: `jl_nextpc`

## Requirements
- R1: When the instruction is not a jump and `branch_take` is 0, `pc_src` is 00, and both `next_pc` and `pc_plus4` equal `pc`+4 (modulo 2^32).
- R2: When the instruction is not a jump and `branch_take` is 1, `pc_src` is 01 and `next_pc` equals `branch_target`.
- R3: For the plain jump (opcode bits [31:26] = 000010), `pc_src` is 11 and `next_pc` = {(`pc`+4)[31:28], `instr`[25:0], 2'b00}.
- R4: For the plain jump, `wr_en` is 0 whatever `reg_write_in` is.
- R5: For the saving jump (opcode 000011), `pc_src` is 11 and `next_pc` follows the R3 rule. In addition, `wr_en` is 1, `wr_reg` is 31 and `wr_data` equals `pc`+4.
- R6: For the register jump (opcode 000000 with function bits [5:0] = 001000), `pc_src` is 10, `next_pc` equals `rs_val` and `wr_en` is 0.
- R7: For every instruction other than the three jumps, `wr_reg` equals `dest_in`, `wr_data` equals `wb_in` and `wr_en` equals `reg_write_in`.
- R8: A decoded jump of any of the three kinds overrides `branch_take`.
- R9: The upper four target bits come from `pc`+4, not from `pc`. A jump located at xxxFFFFFFC therefore lands in the next 256 MB region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Current instruction word |
| pc | input | 32 | Address of the current instruction |
| branch_take | input | 1 | Branch condition met (evaluated outside) |
| branch_target | input | 32 | Branch destination address |
| rs_val | input | 32 | Value read from the rs register |
| dest_in | input | 5 | Normal destination register number |
| wb_in | input | 32 | Normal write-back value (ALU or memory) |
| reg_write_in | input | 1 | Normal register write enable |
| next_pc | output | 32 | Selected next program counter |
| pc_src | output | 2 | Next-PC source code (00 seq, 01 branch, 10 reg, 11 jump) |
| pc_plus4 | output | 32 | Sequential address pc+4 |
| wr_reg | output | 5 | Destination register number after link override |
| wr_data | output | 32 | Write-back value after link override |
| wr_en | output | 1 | Register write enable after jump override |

## Verification
The hardest case to reach from the ports is the region crossing in R9. It only shows up when the jump sits at the last word of a 256 MB region, because only there do the top bits of PC+4 differ from those of the PC. The stimulus therefore sweeps every opcode and every function code, for both branch levels. It does this at several PC values chosen to include such a last-word address, and at that address it checks the saving jump's target and its link value explicitly.

// File: rtl/jl_pkg.sv
package jl_pkg;
    localparam int XLEN      = 32;
    localparam int REG_AW    = 5;
    localparam int OPC_W     = 6;
    localparam int FUN_W     = 6;
    localparam int JIDX_W    = 26;
    localparam int LINK_REG  = 31;

    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_JUMP    = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_JLINK   = 6'b000011;
    localparam logic [FUN_W-1:0] FUN_JREG    = 6'b001000;

    typedef enum logic [1:0] {
        SEL_SEQ    = 2'b00,
        SEL_BRANCH = 2'b01,
        SEL_REGJMP = 2'b10,
        SEL_ABSJMP = 2'b11
    } pcsel_e;

    typedef enum logic [1:0] {
        KIND_OTHER = 2'b00,
        KIND_JUMP  = 2'b01,
        KIND_JLINK = 2'b10,
        KIND_JREG  = 2'b11
    } jkind_e;
endpackage

// File: rtl/jl_decode.sv
module jl_decode
    import jl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FUN_W-1:0] funct,
    input  logic             branch_take,
    input  logic             reg_write_in,
    output jkind_e           kind,
    output pcsel_e           sel,
    output logic             link,
    output logic             wr_en
);
    always_comb begin
        kind = KIND_OTHER;
        unique case (opcode)
            OPC_JUMP:    kind = KIND_JUMP;
            OPC_JLINK:   kind = KIND_JLINK;
            OPC_SPECIAL: kind = (funct == FUN_JREG) ? KIND_JREG : KIND_OTHER;
            default:     kind = KIND_OTHER;
        endcase
    end

    always_comb begin
        sel   = SEL_SEQ;
        link  = 1'b0;
        wr_en = reg_write_in;
        unique case (kind)
            KIND_JUMP: begin
                sel   = SEL_ABSJMP;
                wr_en = 1'b0;
            end
            KIND_JLINK: begin
                sel   = SEL_ABSJMP;
                link  = 1'b1;
                wr_en = 1'b1;
            end
            KIND_JREG: begin
                sel   = SEL_REGJMP;
                wr_en = 1'b0;
            end
            default: begin
                sel = branch_take ? SEL_BRANCH : SEL_SEQ;
            end
        endcase
    end

    always_comb begin
        if (kind == KIND_JUMP) assert (!wr_en) else $error("AST_J_NO_WRITE"); // R4
        if (kind == KIND_JREG) assert (sel == SEL_REGJMP && !wr_en) else $error("AST_JR_SELECT"); // R6
    end
endmodule

// File: rtl/jl_target.sv
module jl_target
    import jl_pkg::*;
(
    input  logic [XLEN-1:0]   pc,
    input  logic [JIDX_W-1:0] jidx,
    output logic [XLEN-1:0]   pc_plus4,
    output logic [XLEN-1:0]   jump_target
);
    localparam int TOP_W = XLEN - JIDX_W - 2;

    logic [TOP_W-1:0] region;

    always_comb begin
        pc_plus4    = pc + XLEN'(4);
        region      = pc_plus4[XLEN-1 -: TOP_W];
        jump_target = {region, jidx, 2'b00};
    end
endmodule

// File: rtl/jl_pcmux.sv
module jl_pcmux
    import jl_pkg::*;
(
    input  pcsel_e          sel,
    input  logic [XLEN-1:0] seq_pc,
    input  logic [XLEN-1:0] br_pc,
    input  logic [XLEN-1:0] reg_pc,
    input  logic [XLEN-1:0] jmp_pc,
    output logic [XLEN-1:0] next_pc
);
    always_comb begin
        unique case (sel)
            SEL_SEQ:    next_pc = seq_pc;
            SEL_BRANCH: next_pc = br_pc;
            SEL_REGJMP: next_pc = reg_pc;
            SEL_ABSJMP: next_pc = jmp_pc;
            default:    next_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/jl_wbmux.sv
module jl_wbmux
    import jl_pkg::*;
(
    input  logic              link,
    input  logic [REG_AW-1:0] dest_in,
    input  logic [XLEN-1:0]   wb_in,
    input  logic [XLEN-1:0]   ret_addr,
    output logic [REG_AW-1:0] wr_reg,
    output logic [XLEN-1:0]   wr_data
);
    localparam logic [REG_AW-1:0] LINK_NUM = REG_AW'(LINK_REG);

    always_comb begin
        wr_reg  = link ? LINK_NUM : dest_in;
        wr_data = link ? ret_addr : wb_in;
    end
endmodule

// File: rtl/jl_nextpc.sv
module jl_nextpc
    import jl_pkg::*;
(
    input  logic [31:0] instr,
    input  logic [31:0] pc,
    input  logic        branch_take,
    input  logic [31:0] branch_target,
    input  logic [31:0] rs_val,
    input  logic [4:0]  dest_in,
    input  logic [31:0] wb_in,
    input  logic        reg_write_in,
    output logic [31:0] next_pc,
    output logic [1:0]  pc_src,
    output logic [31:0] pc_plus4,
    output logic [4:0]  wr_reg,
    output logic [31:0] wr_data,
    output logic        wr_en
);
    jkind_e            kind;
    pcsel_e            sel;
    logic              link;
    logic [XLEN-1:0]   jump_target;

    jl_decode u_decode (
        .opcode       (instr[XLEN-1 -: OPC_W]),
        .funct        (instr[FUN_W-1:0]),
        .branch_take  (branch_take),
        .reg_write_in (reg_write_in),
        .kind         (kind),
        .sel          (sel),
        .link         (link),
        .wr_en        (wr_en)
    );

    jl_target u_target (
        .pc          (pc),
        .jidx        (instr[JIDX_W-1:0]),
        .pc_plus4    (pc_plus4),
        .jump_target (jump_target)
    );

    jl_pcmux u_pcmux (
        .sel     (sel),
        .seq_pc  (pc_plus4),
        .br_pc   (branch_target),
        .reg_pc  (rs_val),
        .jmp_pc  (jump_target),
        .next_pc (next_pc)
    );

    jl_wbmux u_wbmux (
        .link     (link),
        .dest_in  (dest_in),
        .wb_in    (wb_in),
        .ret_addr (pc_plus4),
        .wr_reg   (wr_reg),
        .wr_data  (wr_data)
    );

    assign pc_src = sel;

    always_comb begin
        if (sel == SEL_SEQ) assert (next_pc == pc_plus4) else $error("AST_SEQ_PATH"); // R1
        if (sel == SEL_ABSJMP) assert (next_pc[1:0] == 2'b00 && next_pc[31:28] == pc_plus4[31:28]) else $error("AST_JUMP_REGION"); // R3
        if (link) assert (wr_en && wr_reg == 5'd31 && wr_data == pc_plus4) else $error("AST_LINK_WRITE"); // R5
        if (sel == SEL_REGJMP) assert (next_pc == rs_val) else $error("AST_REG_TARGET"); // R6
        if (kind != KIND_OTHER) assert (sel == SEL_ABSJMP || sel == SEL_REGJMP) else $error("AST_JUMP_OVERRIDE"); // R8
    end
endmodule

// File: tb/jl_nextpc_test.sv
module jl_nextpc_test;
    logic        clk = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc = '0;
    logic        branch_take = 1'b0;
    logic [31:0] branch_target = '0;
    logic [31:0] rs_val = '0;
    logic [4:0]  dest_in = '0;
    logic [31:0] wb_in = '0;
    logic        reg_write_in = 1'b0;
    logic [31:0] next_pc;
    logic [1:0]  pc_src;
    logic [31:0] pc_plus4;
    logic [4:0]  wr_reg;
    logic [31:0] wr_data;
    logic        wr_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    jl_nextpc uut (
        .instr(instr), .pc(pc), .branch_take(branch_take),
        .branch_target(branch_target), .rs_val(rs_val), .dest_in(dest_in),
        .wb_in(wb_in), .reg_write_in(reg_write_in), .next_pc(next_pc),
        .pc_src(pc_src), .pc_plus4(pc_plus4), .wr_reg(wr_reg),
        .wr_data(wr_data), .wr_en(wr_en)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h (instr=%h pc=%h br=%0b)",
                     req, what, act, exp, instr, pc, branch_take);
        end
    endtask

    task automatic apply_and_check(input logic [5:0] opc, input logic [5:0] fun,
                                   input logic br, input logic [31:0] pcv, input int seed);
        logic [31:0] p4, exp_pc, exp_data;
        logic [1:0]  exp_src;
        logic [4:0]  exp_reg;
        logic        exp_en;
        string       tag;
        @(negedge clk);
        instr         = {opc, 20'(32'h5A3C1 + seed * 7), fun};
        pc            = pcv;
        branch_take   = br;
        branch_target = 32'h0040_0000 + 32'(seed) * 8;
        rs_val        = 32'h1000_0000 + 32'(seed) * 4;
        dest_in       = 5'(seed);
        wb_in         = 32'hC0DE_0000 ^ 32'(seed);
        reg_write_in  = seed[0];
        p4 = pcv + 32'd4;
        exp_reg = dest_in; exp_data = wb_in; exp_en = reg_write_in;
        if (opc == 6'b000010) begin
            tag = br ? "R3/R4/R8" : "R3/R4";
            exp_src = 2'b11; exp_pc = {p4[31:28], instr[25:0], 2'b00}; exp_en = 1'b0;
        end else if (opc == 6'b000011) begin
            tag = br ? "R5/R8" : "R5";
            exp_src = 2'b11; exp_pc = {p4[31:28], instr[25:0], 2'b00};
            exp_en = 1'b1; exp_reg = 5'd31; exp_data = p4;
        end else if (opc == 6'b000000 && fun == 6'b001000) begin
            tag = br ? "R6/R8" : "R6";
            exp_src = 2'b10; exp_pc = rs_val; exp_en = 1'b0;
        end else if (br) begin
            tag = "R2/R7";
            exp_src = 2'b01; exp_pc = branch_target;
        end else begin
            tag = "R1/R7";
            exp_src = 2'b00; exp_pc = p4;
        end
        #1;
        check(tag, "next_pc", next_pc, exp_pc);
        check(tag, "pc_src", 32'(pc_src), 32'(exp_src));
        check("R1", "pc_plus4", pc_plus4, p4);
        check(tag, "wr_en", 32'(wr_en), 32'(exp_en));
        check(tag, "wr_reg", 32'(wr_reg), 32'(exp_reg));
        check(tag, "wr_data", wr_data, exp_data);
    endtask

    initial begin
        logic [31:0] pcs [4];
        pcs[0] = 32'h0000_0000;
        pcs[1] = 32'h0040_1234 & 32'hFFFF_FFFC;
        pcs[2] = 32'h0FFF_FFFC;
        pcs[3] = 32'hFFFF_FFFC;
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 2; b++) begin
                for (int o = 0; o < 64; o++)
                    apply_and_check(6'(o), 6'(o ^ 6'h15), b[0], pcs[p], o + p * 64);
                for (int f = 0; f < 64; f++)
                    apply_and_check(6'b000000, 6'(f), b[0], pcs[p], f + 300);
            end
        end
        // R9: saving jump at the last word of a region lands in the next region
        @(negedge clk);
        instr = {6'b000011, 26'h000_0010};
        pc = 32'h0FFF_FFFC; branch_take = 1'b0; reg_write_in = 1'b0;
        #1;
        check("R9", "next_pc", next_pc, 32'h1000_0040);
        check("R9", "wr_data", wr_data, 32'h1000_0000);
        // R6: register jump to a word-aligned value
        @(negedge clk);
        instr = {6'b000000, 5'd4, 15'd0, 6'b001000};
        rs_val = 32'h0012_3458; branch_take = 1'b1; reg_write_in = 1'b1;
        #1;
        check("R6", "next_pc", next_pc, 32'h0012_3458);
        check("R6", "wr_en", 32'(wr_en), 32'd0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule